// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmitter with Sync-Error Detection

This block is the transmit side of a frame-synchronized serial port. Software loads words into a one-entry holding buffer. When the shift stage is free, the block moves each word into it. A frame-sync strobe then starts the frame. After a programmable delay of zero to two bit clocks, the word leaves on a single data line, most significant bit first, one bit per clock. The bit clock and the frame-sync strobe come from outside the block.

A frame-sync strobe can arrive while a word is still in its delay or shift phase. The block treats this as a framing fault and does not lose or corrupt data. It sets a sticky error flag and sends the current word again from its first bit. A control input can instead make the block ignore such mid-frame strobes. The interrupt output follows either the buffer-ready flag or the error event, as a two-bit mode selects.

Top module: `fsync_tx_port`

## Requirements
- R1: Words of WORD_W bits (default 8) leave on `dx_o` most significant bit first, one bit per clock, and `dx_o` is 0 whenever no word is in its shift phase.
- R2: Let d be the delay code on `dly_i`, with code 3 behaving as 2. If `fs_i` is sampled high at edge k, the first bit is driven after edge k+d.
- R3: A write (`wr_en_i`) drops `ready_o` after the writing edge. The buffered word moves to the shift stage only when that stage is empty or is driving its last bit. `ready_o` is high again after the edge that makes this move.
- R4: With `fs_ignore_i` = 0, a strobe sampled while a word is in its delay phase, or is shifting any bit except its last, sets `sync_err_o`. The same word then restarts from its most significant bit under the current delay.
- R5: `sync_err_o` stays set until `err_clr_i` or `tx_rst_i` is sampled high. If a new fault and `err_clr_i` arrive in the same cycle, the fault wins.
- R6: A strobe is never a fault in these cases: it is the first one after a transmitter reset, it arrives while the port is idle, or it arrives during the last bit of a word. If no word is loaded, the strobe starts nothing. A strobe during the last bit, with a word waiting in the buffer, starts that word with no gap.
- R7: With `fs_ignore_i` = 1, a mid-frame strobe has no effect. The flag stays clear and the current word completes unchanged.
- R8: The interrupt mode is set on `int_mode_i`. In mode 2'b11, `irq_o` is a one-cycle pulse for each detected fault, high in the same cycle that `sync_err_o` is first seen set. In mode 2'b00, `irq_o` equals `ready_o`. In modes 2'b01 and 2'b10, `irq_o` is 0.
- R9: While `tx_rst_i` is high (synchronous, active-high), the block aborts any frame and empties the buffer and the shift stage. It also clears `sync_err_o` and holds `ready_o` low. `ready_o` rises after the first edge with `tx_rst_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_rst_i | input | 1 | Synchronous transmitter reset, active high |
| wr_en_i | input | 1 | Write strobe for the holding buffer |
| wr_data_i | input | WORD_W | Word to transmit |
| fs_i | input | 1 | Frame-sync strobe |
| dly_i | input | 2 | Data delay code (0, 1, 2; 3 acts as 2) |
| fs_ignore_i | input | 1 | Ignore mid-frame strobes when high |
| int_mode_i | input | 2 | Interrupt source select |
| err_clr_i | input | 1 | Clears the sync-error flag |
| dx_o | output | 1 | Serial data out |
| ready_o | output | 1 | Holding buffer free for a write |
| sync_err_o | output | 1 | Sticky frame-sync error flag |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
The bench injects a strobe into the third bit of a frame. It expects the flag and a single interrupt pulse in the same cycle, followed by the whole word sent again. A design that drops the word, or goes on from the interrupted bit, shows a different bit stream. The bench also injects a strobe into the last bit while a second word is buffered. It expects both words back to back with no flag set, so a design whose fault window is one bit too wide raises a false error. Other cases check that a mid-frame strobe is harmless with the ignore control set, and that a strobe with nothing loaded leaves the line low. Further cases check delay code 3 and the clearing and masking of the flag and the ready signal by transmitter reset.

// File: rtl/fsync_tx_pkg.sv
`timescale 1ns/1ps
package fsync_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;

  localparam int unsigned DLY_W = 2;

  // delay code 3 behaves as 2
  function automatic logic [DLY_W-1:0] eff_dly(input logic [DLY_W-1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/fsync_tx_buffer.sv
`timescale 1ns/1ps
module fsync_tx_buffer #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_rst_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] buf_o,
  output logic              full_o,
  output logic              ready_o
);

  logic [WORD_W-1:0] buf_q;
  logic              full_q, full_d;
  logic              ready_q;

  always_comb begin
    if (tx_rst_i)     full_d = 1'b0;
    else if (wr_en_i) full_d = 1'b1;
    else if (load_i)  full_d = 1'b0;
    else              full_d = full_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      full_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (wr_en_i && !tx_rst_i) buf_q <= wr_data_i;
      full_q  <= full_d;
      ready_q <= !tx_rst_i && !full_d;
    end
  end

  assign buf_o   = buf_q;
  assign full_o  = full_q;
  assign ready_o = ready_q;

endmodule

// File: rtl/fsync_tx_shifter.sv
`timescale 1ns/1ps
module fsync_tx_shifter
  import fsync_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_rst_i,
  input  logic              word_avail_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              fs_i,
  input  logic [DLY_W-1:0]  dly_i,
  input  logic              fs_ignore_i,
  output logic              load_o,
  output logic              unexp_o,
  output logic              dx_o
);

  localparam int unsigned BIT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  tx_state_e         state_q;
  logic [WORD_W-1:0] word_q;
  logic              loaded_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DLY_W-1:0]  cnt_q;
  logic [DLY_W-1:0]  dly_eff;

  logic last_bit, in_frame, unexp, load, have_word, start;

  assign dly_eff = eff_dly(dly_i);

  always_comb begin
    last_bit  = (state_q == ST_SHIFT) && (bit_q == LAST_BIT);
    in_frame  = (state_q == ST_DELAY) || ((state_q == ST_SHIFT) && !last_bit);
    unexp     = fs_i && in_frame && !fs_ignore_i;
    load      = word_avail_i && (!loaded_q || last_bit);
    // a word is ready to frame: loaded and idle, or arriving this edge
    have_word = ((state_q == ST_IDLE) && loaded_q) || load;
    start     = fs_i && !in_frame && have_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      word_q   <= '0;
      loaded_q <= 1'b0;
      bit_q    <= '0;
      cnt_q    <= '0;
    end else if (tx_rst_i) begin
      state_q  <= ST_IDLE;
      loaded_q <= 1'b0;
      bit_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (load) word_q <= word_i;

      if (start || unexp) begin
        bit_q <= '0;
        if (dly_eff == '0) begin
          state_q <= ST_SHIFT;
        end else begin
          state_q <= ST_DELAY;
          cnt_q   <= dly_eff - 2'd1;
        end
      end else begin
        unique case (state_q)
          ST_DELAY: begin
            if (cnt_q == '0) begin
              state_q <= ST_SHIFT;
              bit_q   <= '0;
            end else begin
              cnt_q <= cnt_q - 2'd1;
            end
          end
          ST_SHIFT: begin
            if (last_bit) state_q <= ST_IDLE;
            else          bit_q   <= bit_q + 1'b1;
          end
          default: ;
        endcase
      end

      if (load)          loaded_q <= 1'b1;
      else if (last_bit) loaded_q <= 1'b0;
    end
  end

  assign load_o  = load && !tx_rst_i;
  assign unexp_o = unexp && !tx_rst_i;
  assign dx_o    = (state_q == ST_SHIFT) ? word_q[LAST_BIT - bit_q] : 1'b0;

endmodule

// File: rtl/fsync_tx_irq.sv
`timescale 1ns/1ps
module fsync_tx_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_rst_i,
  input  logic       unexp_i,
  input  logic       err_clr_i,
  input  logic       ready_i,
  input  logic [1:0] int_mode_i,
  output logic       sync_err_o,
  output logic       irq_o
);

  logic err_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else if (tx_rst_i) begin
      err_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= unexp_i;
      if (unexp_i)        err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (int_mode_i)
      2'b00:   irq_o = ready_i;
      2'b11:   irq_o = pulse_q;
      default: irq_o = 1'b0;
    endcase
  end

  assign sync_err_o = err_q;

endmodule

// File: rtl/fsync_tx_port.sv
`timescale 1ns/1ps
module fsync_tx_port
  import fsync_tx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_rst_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              fs_i,
  input  logic [1:0]        dly_i,
  input  logic              fs_ignore_i,
  input  logic [1:0]        int_mode_i,
  input  logic              err_clr_i,
  output logic              dx_o,
  output logic              ready_o,
  output logic              sync_err_o,
  output logic              irq_o
);

  logic [WORD_W-1:0] buf_word;
  logic              buf_full, load, unexp, ready;

  fsync_tx_buffer #(.WORD_W(WORD_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_rst_i  (tx_rst_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .load_i    (load),
    .buf_o     (buf_word),
    .full_o    (buf_full),
    .ready_o   (ready)
  );

  fsync_tx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tx_rst_i     (tx_rst_i),
    .word_avail_i (buf_full),
    .word_i       (buf_word),
    .fs_i         (fs_i),
    .dly_i        (dly_i),
    .fs_ignore_i  (fs_ignore_i),
    .load_o       (load),
    .unexp_o      (unexp),
    .dx_o         (dx_o)
  );

  fsync_tx_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_rst_i   (tx_rst_i),
    .unexp_i    (unexp),
    .err_clr_i  (err_clr_i),
    .ready_i    (ready),
    .int_mode_i (int_mode_i),
    .sync_err_o (sync_err_o),
    .irq_o      (irq_o)
  );

  assign ready_o = ready;

endmodule

// File: rtl/fsync_tx_port_chk.sv
`timescale 1ns/1ps
module fsync_tx_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_rst_i,
  input logic       wr_en_i,
  input logic       fs_i,
  input logic       fs_ignore_i,
  input logic [1:0] int_mode_i,
  input logic       err_clr_i,
  input logic       dx_o,
  input logic       ready_o,
  input logic       sync_err_o,
  input logic       irq_o
);

  // R5
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_err_o && !err_clr_i && !tx_rst_i) |=> sync_err_o);

  // R4
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_err_o) |-> ($past(fs_i) && !$past(fs_ignore_i)));

  // R7
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fs_ignore_i && !tx_rst_i) |=> !$rose(sync_err_o));

  // R8
  irq_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_mode_i == 2'b11 && irq_o) |-> sync_err_o);

  // R3
  wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !tx_rst_i) |=> !ready_o);

  // R9
  txrst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_i |=> (!sync_err_o && !ready_o && !dx_o));

endmodule

bind fsync_tx_port fsync_tx_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_rst_i    (tx_rst_i),
  .wr_en_i     (wr_en_i),
  .fs_i        (fs_i),
  .fs_ignore_i (fs_ignore_i),
  .int_mode_i  (int_mode_i),
  .err_clr_i   (err_clr_i),
  .dx_o        (dx_o),
  .ready_o     (ready_o),
  .sync_err_o  (sync_err_o),
  .irq_o       (irq_o)
);

// File: tb/fsync_tx_port_tb.sv
`timescale 1ns/1ps
module fsync_tx_port_tb;

  localparam int unsigned W = 8;
  localparam int unsigned NV = 6;
  // {data, delay code}
  localparam logic [9:0] VECS [NV] = '{
    {8'hA5, 2'd0}, {8'h3C, 2'd1}, {8'h81, 2'd2},
    {8'hF0, 2'd3}, {8'h01, 2'd0}, {8'h7E, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_rst = 1'b0, wr_en = 1'b0, fs = 1'b0, fs_ign = 1'b0, err_clr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [1:0] dly = 2'd0, imode = 2'b00;
  logic dx, ready, serr, irq;

  int total = 0;
  int fails = 0;
  logic [15:0] got;

  always #2 clk = ~clk;

  fsync_tx_port #(.WORD_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_rst_i(tx_rst), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .fs_i(fs), .dly_i(dly), .fs_ignore_i(fs_ign),
    .int_mode_i(imode), .err_clr_i(err_clr), .dx_o(dx), .ready_o(ready),
    .sync_err_o(serr), .irq_o(irq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input logic [W-1:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic start_frame(input logic [1:0] code);
    int d;
    d = (code == 2'd3) ? 2 : int'(code);
    dly = code;
    fs = 1'b1;
    step();
    fs = 1'b0;
    repeat (d) step();
  endtask

  // n samples MSB-first; strobe injected after sample index inj
  task automatic collect(input int n, input int inj, output logic [15:0] g);
    g = '0;
    for (int i = 0; i < n; i++) begin
      g = {g[14:0], dx};
      if (i == inj) fs = 1'b1;
      step();
      fs = 1'b0;
    end
  endtask

  initial begin
    #800000;
    fails++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // reset state (R9, R1, R8)
    #5;
    chk(dx == 1'b0 && ready == 1'b0 && serr == 1'b0 && irq == 1'b0, "R9 reset outputs",
        {12'd0, dx, ready, serr, irq}, 16'd0);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk(ready == 1'b1, "R9 ready after reset", 16'(ready), 16'd1);

    // table walk: R1 R2 R3
    for (int v = 0; v < NV; v++) begin
      write_word(VECS[v][9:2]);
      chk(ready == 1'b0, "R3 ready low after write", 16'(ready), 16'd0);
      step();
      chk(ready == 1'b1, "R3 ready after copy", 16'(ready), 16'd1);
      start_frame(VECS[v][1:0]);
      collect(W, -1, got);
      chk(got[7:0] == VECS[v][9:2], "R1 R2 word out", got, 16'(VECS[v][9:2]));
      chk(dx == 1'b0, "R1 line low when idle", 16'(dx), 16'd0);
      chk(serr == 1'b0, "R6 no error on normal frame", 16'(serr), 16'd0);
    end

    // R8 mode 00 tracks ready
    chk(irq == 1'b1, "R8 mode00 irq follows ready", 16'(irq), 16'd1);
    imode = 2'b01;
    #1;
    chk(irq == 1'b0, "R8 mode01 irq silent", 16'(irq), 16'd0);

    // R4 restart + R8 mode 11 pulse
    imode = 2'b11;
    write_word(8'hB4);
    step();
    start_frame(2'd0);
    collect(3, 2, got);
    chk(got[2:0] == 3'b101, "R4 first bits", got, 16'h0005);
    chk(serr == 1'b1, "R4 error flag set", 16'(serr), 16'd1);
    chk(irq == 1'b1, "R8 mode11 pulse", 16'(irq), 16'd1);
    collect(W, -1, got);
    chk(got[7:0] == 8'hB4, "R4 restart from MSB", got, 16'h00B4);
    chk(irq == 1'b0, "R8 single pulse", 16'(irq), 16'd0);
    chk(serr == 1'b1, "R5 flag sticky", 16'(serr), 16'd1);

    // R5 clear
    err_clr = 1'b1;
    step();
    err_clr = 1'b0;
    chk(serr == 1'b0, "R5 clear by write", 16'(serr), 16'd0);

    // R4 strobe during delay phase
    write_word(8'hC3);
    step();
    dly = 2'd2;
    fs = 1'b1; step(); fs = 1'b1; step(); fs = 1'b0;
    chk(serr == 1'b1, "R4 fault in delay phase", 16'(serr), 16'd1);
    step(); step();
    collect(W, -1, got);
    chk(got[7:0] == 8'hC3, "R4 delay restart word", got, 16'h00C3);
    err_clr = 1'b1; step(); err_clr = 1'b0;

    // R7 ignore
    fs_ign = 1'b1;
    write_word(8'h5A);
    step();
    start_frame(2'd1);
    collect(W, 3, got);
    chk(got[7:0] == 8'h5A, "R7 word unbroken", got, 16'h005A);
    chk(serr == 1'b0, "R7 no error", 16'(serr), 16'd0);
    fs_ign = 1'b0;

    // R6 idle strobe with nothing loaded
    fs = 1'b1; step(); fs = 1'b0;
    step();
    chk(dx == 1'b0 && serr == 1'b0, "R6 idle strobe harmless", {14'd0, dx, serr}, 16'd0);

    // R6 back-to-back at last bit
    imode = 2'b00;
    write_word(8'hA1);
    step();
    write_word(8'h3C);
    chk(ready == 1'b0 && irq == 1'b0, "R3 R8 buffer held while loaded", {14'd0, ready, irq}, 16'd0);
    start_frame(2'd0);
    collect(W, W - 1, got);
    chk(got[7:0] == 8'hA1, "R6 first word", got, 16'h00A1);
    chk(ready == 1'b1, "R3 copy at last bit", 16'(ready), 16'd1);
    collect(W, -1, got);
    chk(got[7:0] == 8'h3C, "R6 second word no gap", got, 16'h003C);
    chk(serr == 1'b0, "R6 last-bit strobe not fault", 16'(serr), 16'd0);

    // R9 transmitter reset
    write_word(8'h99);
    step();
    start_frame(2'd0);
    collect(2, 1, got);
    chk(serr == 1'b1, "R9 error before reset", 16'(serr), 16'd1);
    tx_rst = 1'b1;
    step();
    chk(serr == 1'b0 && ready == 1'b0 && dx == 1'b0, "R9 reset clears",
        {13'd0, serr, ready, dx}, 16'd0);
    step();
    chk(ready == 1'b0, "R9 ready held low", 16'(ready), 16'd0);
    tx_rst = 1'b0;
    step();
    chk(ready == 1'b1, "R9 ready after release", 16'(ready), 16'd1);
    write_word(8'h66);
    step();
    start_frame(2'd1);
    collect(W, -1, got);
    chk(got[7:0] == 8'h66 && serr == 1'b0, "R6 first strobe after reset",
        {7'd0, serr, got[7:0]}, 16'h0066);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule